// File: doc/BRIEF.md
# PWM Action Qualifier with Shadowed Software Force

This block sits after a shared time-base counter and turns its events into two PWM output levels, A and B. On every time-base tick it looks at the zero-match and period-match strobes, the counting direction and the current count. It compares the count against two compare values, and each output then moves low, high, toggles or holds according to its own action register. Both outputs run on the one period of the time base. Each output has its own action register, and each action register can react to either compare value.

A software force can hold either output at a fixed level, overriding every event. Software writes the force value into a shadow. A reload-mode field chooses when the shadow becomes active: at a counter-zero tick, at a period tick, at either of them, or at the very next tick. Software programs the block through a single-cycle write port, and reads it back through a combinational read port.

Top module: `pwm_aq_top`

## Requirements
- R1: After reset both outputs are low. The compare, action, reload-mode, force-shadow and active-force registers all read back zero.
- R2: Each 2-bit action code is applied on a tick: 00 holds the output, 01 drives it low, 10 drives it high and 11 inverts it. The new level appears one clock after the tick edge.
- R3: Action register fields: zero-event action at bits 1:0, period-event action at bits 3:2, compare-A-up action at bits 5:4 and compare-B-up action at bits 9:8. Programming zero=10, period=10 and compare-up=01 gives the normal waveform. Programming zero=01, period=01 and compare-up=10 gives the inverted waveform.
- R4: A compare event fires only on a tick where the time base counts up (`cnt_up`=1) and the count equals that compare value. While counting down, an equal count has no effect.
- R5: When several events share a tick, the decision goes to the highest-ranked event whose action code is not 00. The ranking, highest first, is compare-B, compare-A, period, zero. An event with action 00 never hides a lower-ranked one.
- R6: Force codes: output A at force bits 1:0, output B at bits 3:2. Code 01 holds the output low, 10 holds it high, and 00 or 11 leave the events in control. An active force overrides every event for as long as it stays active.
- R7: Reload-mode field at bits 7:6 of address 4. Mode 00 moves the force shadow into the active force only on a tick carrying the zero event. A written force has no effect before that tick.
- R8: Reload mode 01 loads at a period tick, mode 10 loads at a zero or a period tick, and mode 11 loads at the next tick of any kind. The newly loaded value already governs the output on the tick that loads it.
- R9: While `tb_tick` is low, event strobes and count changes leave both outputs unchanged.
- R10: Address map: 0 compare A, 1 compare B, 2 action A, 3 action B, 4 reload mode, 5 force shadow, 6 active force (read-only). A read returns the stored bits with all unused bits zero. A write lands on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_tick | input | 1 | Time-base clock enable; events count only when high |
| evt_zero | input | 1 | Time-base counter is at zero this tick |
| evt_prd | input | 1 | Time-base counter is at the period this tick |
| cnt_up | input | 1 | Time base is counting up |
| tb_count | input | 16 | Current time-base count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| pwm_a | output | 1 | Output A level |
| pwm_b | output | 1 | Output B level |

## Verification
An output level caused by a tick is due one clock after the tick edge. The bench drives each tick for exactly one clock between falling edges and compares the outputs at the next falling edge. A register write takes effect at the edge that samples it. Read data is combinational, so the bench checks it a moment after changing the read address, with no clock in between. Force reloads are checked on the tick that performs them and also on the ticks before it, which shows both that the reload happens at the right point and that it does not happen earlier.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
  localparam int ADDR_W = 3;
  localparam int ACT_W  = 10;
  localparam int FRC_W  = 4;
  localparam int NOUT   = 2;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_INVERT = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    RLD_AT_ZERO = 2'b00,
    RLD_AT_PRD  = 2'b01,
    RLD_AT_BOTH = 2'b10,
    RLD_AT_NEXT = 2'b11
  } rld_e;

  localparam logic [ADDR_W-1:0] ADR_CMP_A  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMP_B  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_ACT_A  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_ACT_B  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_RLD    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FRC    = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_FRC_ON = 3'd6;
endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [FRC_W-1:0]             frc_active,
  output logic [DATA_W-1:0]            rd_data,
  output logic [CNT_W-1:0]             cmp_a,
  output logic [CNT_W-1:0]             cmp_b,
  output logic [NOUT-1:0][ACT_W-1:0]   act,
  output logic [1:0]                   rld_mode,
  output logic [FRC_W-1:0]             frc_shadow
);
  logic ld_cmp_a, ld_cmp_b, ld_rld, ld_frc;
  logic [NOUT-1:0] ld_act;

  always_comb begin
    ld_cmp_a = wr_en && (wr_addr == ADR_CMP_A);
    ld_cmp_b = wr_en && (wr_addr == ADR_CMP_B);
    ld_act[0] = wr_en && (wr_addr == ADR_ACT_A);
    ld_act[1] = wr_en && (wr_addr == ADR_ACT_B);
    ld_rld   = wr_en && (wr_addr == ADR_RLD);
    ld_frc   = wr_en && (wr_addr == ADR_FRC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_a      <= '0;
      cmp_b      <= '0;
      rld_mode   <= '0;
      frc_shadow <= '0;
    end else begin
      if (ld_cmp_a) cmp_a      <= wr_data[CNT_W-1:0];
      if (ld_cmp_b) cmp_b      <= wr_data[CNT_W-1:0];
      if (ld_rld)   rld_mode   <= wr_data[7:6];
      if (ld_frc)   frc_shadow <= wr_data[FRC_W-1:0];
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : gen_act
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          act[g] <= '0;
      else if (ld_act[g])  act[g] <= wr_data[ACT_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADR_CMP_A:  rd_data[CNT_W-1:0] = cmp_a;
      ADR_CMP_B:  rd_data[CNT_W-1:0] = cmp_b;
      ADR_ACT_A:  rd_data[ACT_W-1:0] = act[0];
      ADR_ACT_B:  rd_data[ACT_W-1:0] = act[1];
      ADR_RLD:    rd_data[7:6]       = rld_mode;
      ADR_FRC:    rd_data[FRC_W-1:0] = frc_shadow;
      ADR_FRC_ON: rd_data[FRC_W-1:0] = frc_active;
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_aq_force.sv
module pwm_aq_force
  import pwm_aq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_tick,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic [1:0]       rld_mode,
  input  logic [FRC_W-1:0] frc_shadow,
  output logic [FRC_W-1:0] frc_active,
  output logic [FRC_W-1:0] frc_eff
);
  logic reload_now;
  logic [FRC_W-1:0] frc_active_d;

  always_comb begin
    unique case (rld_e'(rld_mode))
      RLD_AT_ZERO: reload_now = tb_tick && evt_zero;
      RLD_AT_PRD:  reload_now = tb_tick && evt_prd;
      RLD_AT_BOTH: reload_now = tb_tick && (evt_zero || evt_prd);
      RLD_AT_NEXT: reload_now = tb_tick;
      default:     reload_now = 1'b0;
    endcase
    frc_active_d = reload_now ? frc_shadow : frc_active;
    frc_eff      = frc_active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          frc_active <= '0;
    else if (reload_now) frc_active <= frc_active_d;
  end
endmodule

// File: rtl/pwm_aq_chan.sv
module pwm_aq_chan
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_tick,
  input  logic             evt_zero,
  input  logic             evt_prd,
  input  logic             cnt_up,
  input  logic [CNT_W-1:0] tb_count,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [ACT_W-1:0] act,
  input  logic [1:0]       frc,
  output logic             pwm_q
);
  logic hit_ca, hit_cb;
  act_e code;
  logic pwm_d;

  always_comb begin
    hit_ca = cnt_up && (tb_count == cmp_a);
    hit_cb = cnt_up && (tb_count == cmp_b);
    code = ACT_HOLD;
    if (evt_zero && (act[1:0] != 2'b00)) code = act_e'(act[1:0]);
    if (evt_prd  && (act[3:2] != 2'b00)) code = act_e'(act[3:2]);
    if (hit_ca   && (act[5:4] != 2'b00)) code = act_e'(act[5:4]);
    if (hit_cb   && (act[9:8] != 2'b00)) code = act_e'(act[9:8]);
  end

  always_comb begin
    pwm_d = pwm_q;
    if (frc == 2'b01)      pwm_d = 1'b0;
    else if (frc == 2'b10) pwm_d = 1'b1;
    else begin
      unique case (code)
        ACT_LOW:    pwm_d = 1'b0;
        ACT_HIGH:   pwm_d = 1'b1;
        ACT_INVERT: pwm_d = ~pwm_q;
        default:    pwm_d = pwm_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pwm_q <= 1'b0;
    else if (tb_tick) pwm_q <= pwm_d;
  end
endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_tick,
  input  logic              evt_zero,
  input  logic              evt_prd,
  input  logic              cnt_up,
  input  logic [CNT_W-1:0]  tb_count,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic rst_meta, rst_q;
  logic [CNT_W-1:0] cmp_a, cmp_b;
  logic [NOUT-1:0][ACT_W-1:0] act;
  logic [1:0] rld_mode;
  logic [FRC_W-1:0] frc_shadow, frc_active, frc_eff;
  logic [NOUT-1:0] pwm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  pwm_aq_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .frc_active(frc_active),
    .rd_data(rd_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .act(act),
    .rld_mode(rld_mode), .frc_shadow(frc_shadow)
  );

  pwm_aq_force u_force (
    .clk(clk), .rst_n(rst_q), .tb_tick(tb_tick), .evt_zero(evt_zero),
    .evt_prd(evt_prd), .rld_mode(rld_mode), .frc_shadow(frc_shadow),
    .frc_active(frc_active), .frc_eff(frc_eff)
  );

  for (genvar g = 0; g < NOUT; g++) begin : gen_ch
    pwm_aq_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_q), .tb_tick(tb_tick), .evt_zero(evt_zero),
      .evt_prd(evt_prd), .cnt_up(cnt_up), .tb_count(tb_count),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .act(act[g]),
      .frc(frc_eff[2*g +: 2]), .pwm_q(pwm_q[g])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];
endmodule

// File: rtl/pwm_aq_chk.sv
module pwm_aq_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       tb_tick,
  input logic       evt_zero,
  input logic       evt_prd,
  input logic       cnt_up,
  input logic       pwm_a,
  input logic       pwm_b,
  input logic [3:0] frc_eff,
  input logic [3:0] frc_shadow,
  input logic [3:0] frc_active,
  input logic [1:0] rld_mode,
  input logic [9:0] act_a
);
  logic free_a, free_b;
  assign free_a = (frc_eff[1:0] == 2'b00) || (frc_eff[1:0] == 2'b11);
  assign free_b = (frc_eff[3:2] == 2'b00) || (frc_eff[3:2] == 2'b11);

  p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_q)
    !tb_tick |=> ($stable(pwm_a) && $stable(pwm_b)));

  p_force_high_a_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (tb_tick && frc_eff[1:0] == 2'b10) |=> pwm_a);

  p_force_low_b_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (tb_tick && frc_eff[3:2] == 2'b01) |=> !pwm_b);

  p_invert_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (tb_tick && evt_zero && !evt_prd && !cnt_up && free_a && act_a[1:0] == 2'b11)
      |=> (pwm_a != $past(pwm_a)));

  p_down_no_cmp_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (tb_tick && !cnt_up && !evt_zero && !evt_prd && free_a && free_b)
      |=> ($stable(pwm_a) && $stable(pwm_b)));

  p_next_reload_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (tb_tick && rld_mode == 2'b11) |=> (frc_active == $past(frc_shadow)));

  p_zero_only_reload_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (rld_mode == 2'b00 && !(tb_tick && evt_zero)) |=> $stable(frc_active));
endmodule

bind pwm_aq_top pwm_aq_chk u_chk (
  .clk(clk), .rst_q(rst_q), .tb_tick(tb_tick), .evt_zero(evt_zero),
  .evt_prd(evt_prd), .cnt_up(cnt_up), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .frc_eff(frc_eff), .frc_shadow(frc_shadow), .frc_active(frc_active),
  .rld_mode(rld_mode), .act_a(act[0])
);

// File: tb/pwm_aq_top_tb.sv
module pwm_aq_top_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_tick = 1'b0, evt_zero = 1'b0, evt_prd = 1'b0, cnt_up = 1'b0;
  logic [15:0] tb_count = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic pwm_a, pwm_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_aq_top u_dut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .evt_zero(evt_zero),
    .evt_prd(evt_prd), .cnt_up(cnt_up), .tb_count(tb_count),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // {zero, prd, up, count[15:0], exp_a, exp_b}; cmp_a=3, cmp_b=5, normal polarity
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 16'd0, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'd3, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'd5, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 16'd7, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'd3, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b0, 16'd5, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'd3, 1'b0, 1'b1},
    {1'b0, 1'b0, 1'b1, 16'd5, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [15:0] exp);
    rd_addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic step(input logic t, input logic z, input logic p, input logic u,
                      input logic [15:0] c);
    @(negedge clk);
    tb_tick = t; evt_zero = z; evt_prd = p; cnt_up = u; tb_count = c;
    @(negedge clk);
    tb_tick = 1'b0; evt_zero = 1'b0; evt_prd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pwm_a", {15'd0, pwm_a}, 16'd0);
    chk("R1 pwm_b", {15'd0, pwm_b}, 16'd0);
    rd("R1 cmp_a", 3'd0, 16'h0000);
    rd("R1 act_b", 3'd3, 16'h0000);
    rd("R1 reload", 3'd4, 16'h0000);
    rd("R1 shadow", 3'd5, 16'h0000);
    rd("R1 active", 3'd6, 16'h0000);

    // R3/R4 normal waveform table
    wr(3'd0, 16'd3);
    wr(3'd1, 16'd5);
    wr(3'd2, 16'h001A);
    wr(3'd3, 16'h010A);
    for (int i = 0; i < 8; i++) begin
      step(1'b1, VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17:2]);
      chk($sformatf("R3 R4 vec%0d a", i), {15'd0, pwm_a}, {15'd0, VEC[i][1]});
      chk($sformatf("R3 R4 vec%0d b", i), {15'd0, pwm_b}, {15'd0, VEC[i][0]});
    end

    // R3 inverted polarity on A
    wr(3'd2, 16'h0025);
    step(1, 1, 0, 1, 16'd0);
    chk("R3 inverted zero", {15'd0, pwm_a}, 16'd0);
    step(1, 0, 0, 1, 16'd3);
    chk("R3 inverted cmp", {15'd0, pwm_a}, 16'd1);

    // R5 priority
    wr(3'd0, 16'd4);
    wr(3'd1, 16'd4);
    wr(3'd2, 16'h0127);
    step(1, 1, 1, 1, 16'd4);
    chk("R5 cmpB wins", {15'd0, pwm_a}, 16'd0);
    wr(3'd2, 16'h0027);
    step(1, 1, 1, 1, 16'd4);
    chk("R5 cmpA over prd", {15'd0, pwm_a}, 16'd1);
    wr(3'd2, 16'h0007);
    step(1, 1, 1, 1, 16'd4);
    chk("R5 prd over zero", {15'd0, pwm_a}, 16'd0);

    // R2 invert and hold
    wr(3'd2, 16'h0003);
    step(1, 1, 0, 0, 16'd0);
    chk("R2 invert 1", {15'd0, pwm_a}, 16'd1);
    step(1, 1, 0, 0, 16'd0);
    chk("R2 invert 2", {15'd0, pwm_a}, 16'd0);
    step(1, 0, 1, 0, 16'd9);
    chk("R2 hold 00", {15'd0, pwm_a}, 16'd0);

    // R9 no tick
    step(0, 1, 0, 0, 16'd0);
    chk("R9 no tick", {15'd0, pwm_a}, 16'd0);

    // R4 down-count equal compare
    wr(3'd2, 16'h0020);
    step(1, 0, 0, 0, 16'd4);
    chk("R4 down no match", {15'd0, pwm_a}, 16'd0);
    step(1, 0, 0, 1, 16'd5);
    chk("R4 up unequal", {15'd0, pwm_a}, 16'd0);
    step(1, 0, 0, 1, 16'd4);
    chk("R4 up match", {15'd0, pwm_a}, 16'd1);

    // R6/R7 force low on A, reload at zero
    wr(3'd2, 16'h0002);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'h0001);
    step(1, 0, 1, 1, 16'd9);
    chk("R7 no load at prd", {15'd0, pwm_a}, 16'd1);
    rd("R7 active before zero", 3'd6, 16'h0000);
    step(1, 1, 0, 1, 16'd0);
    chk("R6 force beats zero high", {15'd0, pwm_a}, 16'd0);
    rd("R7 active after zero", 3'd6, 16'h0001);
    step(1, 1, 0, 1, 16'd0);
    chk("R6 force persists", {15'd0, pwm_a}, 16'd0);

    // R8 reload at period
    wr(3'd4, 16'h0040);
    wr(3'd5, 16'h0002);
    step(1, 1, 0, 1, 16'd0);
    chk("R8 mode01 not at zero", {15'd0, pwm_a}, 16'd0);
    step(1, 0, 1, 1, 16'd9);
    chk("R8 mode01 at prd", {15'd0, pwm_a}, 16'd1);

    // R8 reload at either
    wr(3'd4, 16'h0080);
    wr(3'd2, 16'h0010);
    wr(3'd5, 16'h0000);
    step(1, 0, 1, 1, 16'd4);
    chk("R8 mode10 release at prd", {15'd0, pwm_a}, 16'd0);
    wr(3'd5, 16'h0002);
    step(1, 1, 0, 1, 16'd0);
    chk("R8 mode10 load at zero", {15'd0, pwm_a}, 16'd1);

    // R8 reload at next tick; force code 11 releases A
    wr(3'd4, 16'h00C0);
    wr(3'd5, 16'h0000);
    step(1, 1, 0, 1, 16'd0);
    chk("R8 mode11 b high", {15'd0, pwm_b}, 16'd1);
    wr(3'd5, 16'h0007);
    rd("R8 no load without tick", 3'd6, 16'h0000);
    step(1, 0, 0, 1, 16'd7);
    chk("R6 code11 leaves a", {15'd0, pwm_a}, 16'd1);
    chk("R8 mode11 b forced low", {15'd0, pwm_b}, 16'd0);
    rd("R8 active loaded", 3'd6, 16'h0007);

    // R10 readback
    wr(3'd0, 16'hBEEF);
    rd("R10 cmp_a", 3'd0, 16'hBEEF);
    wr(3'd3, 16'hFFFF);
    rd("R10 act_b masked", 3'd3, 16'h03FF);
    wr(3'd4, 16'hFFFF);
    rd("R10 reload masked", 3'd4, 16'h00C0);
    rd("R10 shadow", 3'd5, 16'h0007);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule